// File: doc/BRIEF.md
# Dual Parallel Port with Edge-Flag Detector

This block provides two byte-wide parallel ports, A and B, on a small register bus. Each port has a data register and a direction register. A pin whose direction bit is 0 is an input, and the block drives it high instead of leaving it floating. A pin whose direction bit is 1 is an output and follows its data bit. Reads of a data register merge the driven levels with the levels seen on the external pins. The two ports use different merge rules. On port B, an output pin reads back only the register value.

The external level of port A bit 7 passes through a synchroniser and then feeds an edge detector. Software sets the detector's polarity to rising or falling with a write whose address carries the choice. A detected edge sets a sticky flag. The flag appears in bit 6 of a shared flag register. Bit 7 of that register reports a timer flag that comes from outside the block. Reading the flag register clears the edge flag, unless a new edge arrives in the same cycle.

Top module: `pio_port`

## Requirements
- R1: Synchronous active-high reset clears both data registers and both direction registers to 0x00 and selects falling-edge detection. After reset, pa_out and pb_out are therefore 0xFF.
- R2: With addr[2]=0, addr[1:0] selects the register: 0 is the port A data register, 1 the port A direction register, 2 the port B data register and 3 the port B direction register. A direction register reads back exactly the value written to it.
- R3: For every bit, the driven pin level equals the data bit OR the inverse of the direction bit. Direction 1 means output, and an input pin is driven high.
- R4: A read of the port A data register returns (data OR NOT direction) AND pa_in.
- R5: A read of the port B data register returns (data OR NOT direction) AND (pb_in OR direction). Output pins therefore read back only the register contents.
- R6: A write with addr[2]=1 and addr[4]=0 sets the edge polarity from addr[0], where 1 means rising and 0 means falling. A write with addr[2]=1 and addr[4]=1 changes neither the polarity nor any port register.
- R7: The edge flag is set only by a transition of pa_in[7] in the selected direction. The transition in the other direction is ignored. The input passes through two flops, so the flag is set on the third rising clock edge after the pin changes.
- R8: A read with addr[2]=1 and addr[0]=1 returns timer_flag_in in bit 7, the edge flag in bit 6 and zeros elsewhere. The read then clears the edge flag and has no effect on bit 7.
- R9: When a qualifying edge arrives in the same cycle as a flag-register read, the edge flag stays set.
- R10: A read with addr[2]=1 and addr[0]=0 returns 0x00 and leaves the edge flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel | input | 1 | Bus access targets this block |
| wr | input | 1 | Write strobe |
| rd | input | 1 | Read strobe; a flag-register read clears the edge flag |
| addr | input | 5 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational, 0 when no read is selected |
| pa_in | input | 8 | External levels on port A pins |
| pb_in | input | 8 | External levels on port B pins |
| timer_flag_in | input | 1 | Timer flag from outside, shown in flag bit 7 |
| pa_out | output | 8 | Driven levels on port A pins |
| pb_out | output | 8 | Driven levels on port B pins |

## Verification
A corrupted data or direction register shows up on pa_out or pb_out in the very next cycle. It also changes the readback value the next time that offset is read. A polarity register that holds the wrong value shows nothing until pa_in[7] moves. Then the flag sets on the wrong transition, three clocks later. For that reason the polarity is tested with both edge directions after every polarity write, including the write that must be ignored. A bad edge flag, whether it is lost, never cleared or cleared over a coinciding edge, is visible only through bit 6 of the flag register. So the same-cycle case is aligned with the synchroniser latency and is followed by a second read.

// File: rtl/pio_pkg.sv
package pio_pkg;

    localparam int PIO_W     = 8;
    localparam int PIO_AW    = 5;
    localparam int SYNC_LEN  = 2;
    localparam int FLG_TIMER = 7;
    localparam int FLG_EDGE  = 6;

    typedef struct packed {
        logic [PIO_W-1:0] data;
        logic [PIO_W-1:0] dir;
    } port_regs_t;

    typedef enum logic [1:0] {
        SEL_A_DATA = 2'd0,
        SEL_A_DIR  = 2'd1,
        SEL_B_DATA = 2'd2,
        SEL_B_DIR  = 2'd3
    } port_sel_e;

    typedef enum logic {
        EDGE_FALL = 1'b0,
        EDGE_RISE = 1'b1
    } edge_pol_e;

    function automatic logic [PIO_W-1:0] drive_level(port_regs_t r);
        return r.data | ~r.dir;
    endfunction

    function automatic logic [PIO_W-1:0] merge_a(port_regs_t r, logic [PIO_W-1:0] pins);
        return drive_level(r) & pins;
    endfunction

    function automatic logic [PIO_W-1:0] merge_b(port_regs_t r, logic [PIO_W-1:0] pins);
        return drive_level(r) & (pins | r.dir);
    endfunction

endpackage

// File: rtl/pio_portreg.sv
module pio_portreg
    import pio_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_data,
    input  logic             wr_dir,
    input  logic [PIO_W-1:0] wdata,
    output port_regs_t       regs
);
    always_ff @(posedge clk) begin
        if (rst) begin
            regs <= '0;
        end else begin
            if (wr_data) regs.data <= wdata;
            if (wr_dir)  regs.dir  <= wdata;
        end
    end
endmodule

// File: rtl/pio_edge_det.sv
module pio_edge_det
    import pio_pkg::*;
#(
    parameter int STAGES = SYNC_LEN
)(
    input  logic      clk,
    input  logic      rst,
    input  logic      pin,
    input  logic      pol_wr,
    input  logic      pol_val,
    input  logic      flag_rd,
    output logic      edge_flag,
    output logic      edge_hit,
    output edge_pol_e pol
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;
    logic              cur;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '1;
                else     sync_q <= pin;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '1;
                else     sync_q <= {sync_q[STAGES-2:0], pin};
            end
        end
    endgenerate

    assign cur = sync_q[STAGES-1];

    always_comb begin
        if (pol == EDGE_RISE) edge_hit = ~prev_q & cur;
        else                  edge_hit = prev_q & ~cur;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q    <= 1'b1;
            pol       <= EDGE_FALL;
            edge_flag <= 1'b0;
        end else begin
            prev_q <= cur;
            if (pol_wr) pol <= edge_pol_e'(pol_val);
            // a new edge takes priority over the clear
            if (edge_hit)     edge_flag <= 1'b1;
            else if (flag_rd) edge_flag <= 1'b0;
        end
    end
endmodule

// File: rtl/pio_port.sv
module pio_port
    import pio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sel,
    input  logic              wr,
    input  logic              rd,
    input  logic [PIO_AW-1:0] addr,
    input  logic [PIO_W-1:0]  wdata,
    output logic [PIO_W-1:0]  rdata,
    input  logic [PIO_W-1:0]  pa_in,
    input  logic [PIO_W-1:0]  pb_in,
    input  logic              timer_flag_in,
    output logic [PIO_W-1:0]  pa_out,
    output logic [PIO_W-1:0]  pb_out
);
    port_regs_t regs_a, regs_b;
    port_sel_e  rsel;
    edge_pol_e  pol;
    logic       io_wr, pol_wr, flag_rd;
    logic       edge_flag, edge_hit;

    assign rsel    = port_sel_e'(addr[1:0]);
    assign io_wr   = sel & wr & ~addr[2];
    assign pol_wr  = sel & wr & addr[2] & ~addr[4];
    assign flag_rd = sel & rd & addr[2] & addr[0];

    pio_portreg u_rega (
        .clk     (clk),
        .rst     (rst),
        .wr_data (io_wr && rsel == SEL_A_DATA),
        .wr_dir  (io_wr && rsel == SEL_A_DIR),
        .wdata   (wdata),
        .regs    (regs_a)
    );

    pio_portreg u_regb (
        .clk     (clk),
        .rst     (rst),
        .wr_data (io_wr && rsel == SEL_B_DATA),
        .wr_dir  (io_wr && rsel == SEL_B_DIR),
        .wdata   (wdata),
        .regs    (regs_b)
    );

    pio_edge_det u_edge (
        .clk       (clk),
        .rst       (rst),
        .pin       (pa_in[PIO_W-1]),
        .pol_wr    (pol_wr),
        .pol_val   (addr[0]),
        .flag_rd   (flag_rd),
        .edge_flag (edge_flag),
        .edge_hit  (edge_hit),
        .pol       (pol)
    );

    assign pa_out = drive_level(regs_a);
    assign pb_out = drive_level(regs_b);

    always_comb begin
        rdata = '0;
        if (sel && rd) begin
            if (!addr[2]) begin
                unique case (rsel)
                    SEL_A_DATA: rdata = merge_a(regs_a, pa_in);
                    SEL_A_DIR:  rdata = regs_a.dir;
                    SEL_B_DATA: rdata = merge_b(regs_b, pb_in);
                    SEL_B_DIR:  rdata = regs_b.dir;
                    default:    rdata = '0;
                endcase
            end else if (addr[0]) begin
                rdata[FLG_TIMER] = timer_flag_in;
                rdata[FLG_EDGE]  = edge_flag;
            end
        end
    end
endmodule

// File: rtl/pio_port_chk.sv
module pio_port_chk
    import pio_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              sel,
    input logic              wr,
    input logic              rd,
    input logic [PIO_AW-1:0] addr,
    input logic [PIO_W-1:0]  wdata,
    input logic [PIO_W-1:0]  pa_out,
    input logic [PIO_W-1:0]  pb_out,
    input logic [PIO_W-1:0]  dir_a,
    input logic              rise_sel,
    input logic              edge_flag,
    input logic              edge_hit
);
    logic pol_w, flag_r;
    assign pol_w  = sel && wr && addr[2] && !addr[4];
    assign flag_r = sel && rd && addr[2] && addr[0];

    assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pa_out == '1 && pb_out == '1 && !rise_sel && !edge_flag));

    assert_dir_write_R2: assert property (@(posedge clk) disable iff (rst)
        (sel && wr && addr[2:0] == 3'd1) |=> dir_a == $past(wdata));

    assert_pol_write_R6: assert property (@(posedge clk) disable iff (rst)
        pol_w |=> rise_sel == $past(addr[0]));

    assert_pol_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !pol_w |=> $stable(rise_sel));

    assert_edge_sets_R7: assert property (@(posedge clk) disable iff (rst)
        edge_hit |=> edge_flag);

    assert_flag_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (!edge_hit && !flag_r) |=> $stable(edge_flag));

    assert_read_clears_R8: assert property (@(posedge clk) disable iff (rst)
        (flag_r && !edge_hit) |=> !edge_flag);
endmodule

bind pio_port pio_port_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .sel       (sel),
    .wr        (wr),
    .rd        (rd),
    .addr      (addr),
    .wdata     (wdata),
    .pa_out    (pa_out),
    .pb_out    (pb_out),
    .dir_a     (regs_a.dir),
    .rise_sel  (pol == pio_pkg::EDGE_RISE),
    .edge_flag (edge_flag),
    .edge_hit  (edge_hit)
);

// File: tb/sim_pio_port.sv
module sim_pio_port;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sel = 1'b0, wr = 1'b0, rd = 1'b0;
    logic [4:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [7:0] pa_in = 8'hFF, pb_in = 8'hFF;
    logic       timer_flag_in = 1'b0;
    logic [7:0] pa_out, pb_out;

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pio_port u0 (
        .clk(clk), .rst(rst), .sel(sel), .wr(wr), .rd(rd), .addr(addr),
        .wdata(wdata), .rdata(rdata), .pa_in(pa_in), .pb_in(pb_in),
        .timer_flag_in(timer_flag_in), .pa_out(pa_out), .pb_out(pb_out)
    );

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(logic [4:0] a, logic [7:0] d);
        @(negedge clk);
        sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        sel = 1'b0; wr = 1'b0;
    endtask

    task automatic bus_rd(logic [4:0] a, output logic [7:0] d);
        @(negedge clk);
        sel = 1'b1; rd = 1'b1; addr = a;
        #1 d = rdata;
        @(negedge clk);
        sel = 1'b0; rd = 1'b0;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    function automatic logic [7:0] exp_a(logic [7:0] d, logic [7:0] r, logic [7:0] p);
        return (d | ~r) & p;
    endfunction

    function automatic logic [7:0] exp_b(logic [7:0] d, logic [7:0] r, logic [7:0] p);
        return (d | ~r) & (p | r);
    endfunction

    task automatic t_reset();
        logic [7:0] v;
        check("R1 pa_out", pa_out, 8'hFF);
        check("R1 pb_out", pb_out, 8'hFF);
        bus_rd(5'd1, v); check("R1 A dir", v, 8'h00);
        bus_rd(5'd3, v); check("R1 B dir", v, 8'h00);
        bus_rd(5'd0, v); check("R1 A data read", v, 8'hFF);
        bus_rd(5'd5, v); check("R1 flag reg", v, 8'h00);
        // falling polarity after reset: rising edge must not set the flag
        pa_in[7] = 1'b0; settle(); bus_rd(5'd5, v);
        pa_in[7] = 1'b1; settle(); bus_rd(5'd5, v); check("R1 default falling", v, 8'h00);
    endtask

    task automatic t_regs();
        logic [7:0] v;
        bus_wr(5'd1, 8'hF0);
        bus_wr(5'd3, 8'hF0);
        bus_wr(5'd0, 8'hA0);
        bus_wr(5'd2, 8'hA0);
        bus_rd(5'd1, v); check("R2 A dir readback", v, 8'hF0);
        bus_rd(5'd3, v); check("R2 B dir readback", v, 8'hF0);
        check("R3 pa_out", pa_out, 8'hAF);
        check("R3 pb_out", pb_out, 8'hAF);
        bus_wr(5'd1, 8'h3C);
        check("R3 pa_out after dir change", pa_out, (8'hA0 | ~8'h3C));
        check("R2 B untouched by A dir write", pb_out, 8'hAF);
        bus_wr(5'd1, 8'hF0);
    endtask

    task automatic t_read_a();
        logic [7:0] v;
        pa_in = 8'hFF; bus_rd(5'd0, v); check("R4 A pins high", v, exp_a(8'hA0, 8'hF0, 8'hFF));
        pa_in = 8'h8F; bus_rd(5'd0, v); check("R4 A pins 8F", v, exp_a(8'hA0, 8'hF0, 8'h8F));
        pa_in = 8'h80; bus_rd(5'd0, v); check("R4 A pins 80", v, exp_a(8'hA0, 8'hF0, 8'h80));
        pa_in = 8'hFF;
    endtask

    task automatic t_read_b();
        logic [7:0] v;
        pb_in = 8'h00; bus_rd(5'd2, v); check("R5 B pins low", v, exp_b(8'hA0, 8'hF0, 8'h00));
        pb_in = 8'h5A; bus_rd(5'd2, v); check("R5 B pins 5A", v, exp_b(8'hA0, 8'hF0, 8'h5A));
        pb_in = 8'hFF; bus_rd(5'd2, v); check("R5 B pins high", v, exp_b(8'hA0, 8'hF0, 8'hFF));
    endtask

    task automatic t_falling();
        logic [7:0] v;
        bus_rd(5'd5, v);
        pa_in[7] = 1'b0; settle();
        bus_rd(5'd5, v); check("R7 falling edge sets flag", v, 8'h40);
        bus_rd(5'd5, v); check("R8 read clears flag", v, 8'h00);
        pa_in[7] = 1'b1; settle();
        bus_rd(5'd5, v); check("R7 rising ignored when falling", v, 8'h00);
    endtask

    task automatic t_rising();
        logic [7:0] v;
        bus_wr(5'b00101, 8'h00);
        pa_in[7] = 1'b0; settle();
        bus_rd(5'd5, v); check("R6 falling ignored when rising", v, 8'h00);
        pa_in[7] = 1'b1; settle();
        bus_rd(5'd5, v); check("R6 rising edge sets flag", v, 8'h40);
        // write with addr[4]=1 and addr[0]=0 must not change polarity
        bus_wr(5'b10100, 8'h55);
        pa_in[7] = 1'b0; settle();
        bus_rd(5'd5, v); check("R6 timer write keeps polarity", v, 8'h00);
        pa_in[7] = 1'b1; settle();
        bus_rd(5'd5, v); check("R6 still rising after timer write", v, 8'h40);
        bus_rd(5'd1, v); check("R6 timer write leaves A dir", v, 8'hF0);
        bus_wr(5'b00100, 8'h00);
    endtask

    task automatic t_flag_reg();
        logic [7:0] v;
        timer_flag_in = 1'b1;
        pa_in[7] = 1'b0; settle();
        bus_rd(5'd4, v); check("R10 timer offset reads zero", v, 8'h00);
        bus_rd(5'd7, v); check("R8 both flags", v, 8'hC0);
        bus_rd(5'd5, v); check("R8 timer bit unaffected", v, 8'h80);
        timer_flag_in = 1'b0;
        pa_in[7] = 1'b1; settle();
    endtask

    task automatic t_collide();
        logic [7:0] v;
        bus_rd(5'd5, v);
        @(negedge clk); pa_in[7] = 1'b0;
        @(negedge clk);
        @(negedge clk);
        sel = 1'b1; rd = 1'b1; addr = 5'd5;
        #1 check("R7 flag not set before third edge", rdata, 8'h00);
        @(negedge clk);
        sel = 1'b0; rd = 1'b0;
        bus_rd(5'd5, v); check("R9 edge beats clear", v, 8'h40);
        bus_rd(5'd5, v); check("R9 later read clears", v, 8'h00);
        pa_in[7] = 1'b1; settle();
    endtask

    initial begin : watchdog
        for (int i = 0; i < 200000; i++) begin
            @(posedge clk);
            if (done) disable watchdog;
        end
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_regs();
        t_read_a();
        t_read_b();
        t_falling();
        t_rising();
        t_flag_reg();
        t_collide();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule